// File: doc/BRIEF.md
# Table-Access Protection and Pointer Unit

This block stands between a processor's table-read and table-write instructions and its program memory. It keeps a 21-bit pointer that steps according to the mode bits in the instruction. It works out which protection region the target address falls in and which region the running instruction was fetched from. It then either issues the memory access or suppresses it. A denied or unimplemented read loads zero into the 8-bit read latch. A denied access of either kind raises a one-cycle error pulse.

Program memory is split into a 512-byte boot region and four 8 KB regions. Each region has three protection bits. The first is an external-access guard, which applies only when an outside programmer drives the access. The second is a write guard for the running program. The third is a foreign-read guard for the running program. Protection bits can only be cleared by configuration writes. Only an erase issued while the external-programmer flag is high sets them back to one.

Top module: `tbl_guard_top`

## Requirements
- R1: Region 0 covers addresses 0x000000–0x0001FF. Region k (k = 1..4) covers the addresses whose bits [20:13] equal k-1, with 0x000200–0x001FFF falling in region 1. Bit k of each protection vector belongs to region k.
- R2: A target at or above 0x008000 is unimplemented. A read there loads 0x00 into `tablat` without issuing `mem_rd` and without raising `deny_err`. A write there issues no `mem_we`.
- R3: When `ext_prog` is 0, a table write to a region whose write-guard bit is 0 issues no `mem_we` and raises `deny_err`. When the bit is 1, it pulses `mem_we` with `mem_wdata` equal to `wr_data`.
- R4: When `ext_prog` is 0, a table read to a region whose foreign-read bit is 0 succeeds only if `instr_addr` lies in that same region. Otherwise it loads 0x00 and raises `deny_err`. A successful read loads `mem_rdata`.
- R5: The external-access guard bits have no effect when `ext_prog` is 0. When `ext_prog` is 1, only those bits apply: a 0 denies both reads (latch 0x00) and writes, and the write-guard and foreign-read bits are ignored.
- R6: A configuration write (`cfg_we`) ANDs each protection vector with its write data, so a bit can only go from 1 to 0. `erase_req` sets every bit to 1 only while `ext_prog` is 1, and erase wins over a simultaneous configuration write. All bits are 1 after reset.
- R7: `tbl_ptr` is 21 bits and wraps modulo 2^21. Mode bits 00 leave it unchanged, 01 add one after the access, 10 subtract one after the access, and 11 add one before the access.
- R8: Opcodes 0x0008–0x000B are table reads and 0x000C–0x000F are table writes, with opcode bits [1:0] as the pointer mode. Any other opcode changes no output.
- R9: Each access takes two cycles. Strobes, `mem_addr` and the pointer update appear after the accepting edge, and `tablat` updates on the following edge. A request presented while an access is in its second cycle is ignored.
- R10: Pre-increment checks and accesses the incremented address. The other modes check and access the pointer value from before the update.
- R11: `deny_err` is high for exactly one cycle per denied access, in the same cycle a permitted access would show its strobe.
- R12: `ptr_load` writes `ptr_load_val` into the pointer. A request in the same cycle as `ptr_load` is ignored. Reset clears the pointer, the latch and all strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode presented this cycle |
| opcode | input | 16 | Instruction word |
| instr_addr | input | 21 | Fetch address of the executing instruction |
| wr_data | input | 8 | Byte for a table write |
| ext_prog | input | 1 | Access or erase driven by an external programmer |
| ptr_load | input | 1 | Load the pointer |
| ptr_load_val | input | 21 | Pointer load value |
| cfg_we | input | 1 | Protection-bit clear request |
| cfg_xg | input | 5 | External-guard write data, one bit per region |
| cfg_wg | input | 5 | Write-guard write data |
| cfg_rg | input | 5 | Foreign-read-guard write data |
| erase_req | input | 1 | Restore all protection bits to 1 |
| mem_rdata | input | 8 | Memory data for the current `mem_addr` |
| mem_addr | output | 21 | Address of the last accepted access |
| mem_rd | output | 1 | Read strobe |
| mem_we | output | 1 | Write-permit strobe |
| mem_wdata | output | 8 | Write byte |
| tablat | output | 8 | Table read latch |
| tbl_ptr | output | 21 | Current pointer |
| deny_err | output | 1 | Access denied pulse |

## Verification
A wrong protection bit shows up at the next access that targets the affected region. That access then gives the wrong strobe or error pulse one cycle after it is accepted, and the wrong latch value one cycle after that. A wrong pointer shows on `tbl_ptr` one cycle after the step, and it also moves every later access to the wrong address. A stuck busy flag shows as a request that is dropped or accepted twice. The bench detects this in the very next pointer comparison.

// File: rtl/tbl_guard_pkg.sv
package tbl_guard_pkg;
  typedef enum logic [1:0] {
    PM_HOLD     = 2'b00,
    PM_POST_INC = 2'b01,
    PM_POST_DEC = 2'b10,
    PM_PRE_INC  = 2'b11
  } ptr_mode_e;

  typedef enum logic [1:0] {
    PD_NONE = 2'b00,
    PD_DATA = 2'b01,
    PD_ZERO = 2'b10
  } pend_e;

  localparam logic [12:0] TBL_OPC_HI = 13'h0001;
endpackage

// File: rtl/tbl_region_dec.sv
module tbl_region_dec #(
  parameter int AW         = 21,
  parameter int BOOT_BYTES = 512,
  parameter int BLK_BYTES  = 8192,
  parameter int NUM_BLKS   = 4,
  localparam int IW        = $clog2(NUM_BLKS + 1)
) (
  input  logic [AW-1:0] addr,
  output logic [IW-1:0] region,
  output logic          implemented
);
  localparam int BLK_SHIFT  = $clog2(BLK_BYTES);
  localparam int IMPL_LIMIT = NUM_BLKS * BLK_BYTES;

  logic [AW-1:0] hi;

  always_comb begin
    hi          = addr >> BLK_SHIFT;
    implemented = (addr < AW'(IMPL_LIMIT));
    if (addr < AW'(BOOT_BYTES)) region = '0;
    else                        region = IW'(hi) + IW'(1);
  end
endmodule

// File: rtl/tbl_prot_bits.sv
module tbl_prot_bits #(
  parameter int NREG = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [NREG-1:0] wd_xg,
  input  logic [NREG-1:0] wd_wg,
  input  logic [NREG-1:0] wd_rg,
  input  logic            erase_req,
  input  logic            ext_prog,
  output logic [NREG-1:0] xg,
  output logic [NREG-1:0] wg,
  output logic [NREG-1:0] rg
);
  logic erase_ok;
  assign erase_ok = erase_req && ext_prog;

  always_ff @(posedge clk) begin
    if (rst || erase_ok) begin
      xg <= '1;
      wg <= '1;
      rg <= '1;
    end else if (cfg_we) begin
      xg <= xg & wd_xg;
      wg <= wg & wd_wg;
      rg <= rg & wd_rg;
    end
  end

  // R6: outside a qualified erase no bit rises
  for (genvar g = 0; g < NREG; g++) begin : g_mono
    a_r6_no_rise: assert property (@(posedge clk) disable iff (rst)
      !erase_ok |=> !($rose(xg[g]) || $rose(wg[g]) || $rose(rg[g])));
  end
endmodule

// File: rtl/tbl_ptr_unit.sv
module tbl_ptr_unit
  import tbl_guard_pkg::*;
#(
  parameter int AW = 21
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step_en,
  input  ptr_mode_e     mode,
  output logic [AW-1:0] ptr,
  output logic [AW-1:0] acc_addr
);
  logic [AW-1:0] ptr_inc, ptr_dec;

  always_comb begin
    ptr_inc  = ptr + AW'(1);
    ptr_dec  = ptr - AW'(1);
    acc_addr = (mode == PM_PRE_INC) ? ptr_inc : ptr;
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step_en) begin
      unique case (mode)
        PM_HOLD:                 ptr <= ptr;
        PM_POST_INC, PM_PRE_INC: ptr <= ptr_inc;
        PM_POST_DEC:             ptr <= ptr_dec;
      endcase
    end
  end

  a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!load && !step_en) |=> $stable(ptr));
  a_r7_post_dec: assert property (@(posedge clk) disable iff (rst)
    (!load && step_en && mode == PM_POST_DEC) |=> (ptr == $past(ptr) - AW'(1)));
  a_r12_load: assert property (@(posedge clk) disable iff (rst)
    load |=> (ptr == $past(load_val)));
endmodule

// File: rtl/tbl_guard_top.sv
module tbl_guard_top
  import tbl_guard_pkg::*;
#(
  parameter int AW         = 21,
  parameter int DW         = 8,
  parameter int BOOT_BYTES = 512,
  parameter int BLK_BYTES  = 8192,
  parameter int NUM_BLKS   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [15:0]       opcode,
  input  logic [AW-1:0]     instr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              ext_prog,
  input  logic              ptr_load,
  input  logic [AW-1:0]     ptr_load_val,
  input  logic              cfg_we,
  input  logic [NUM_BLKS:0] cfg_xg,
  input  logic [NUM_BLKS:0] cfg_wg,
  input  logic [NUM_BLKS:0] cfg_rg,
  input  logic              erase_req,
  input  logic [DW-1:0]     mem_rdata,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_rd,
  output logic              mem_we,
  output logic [DW-1:0]     mem_wdata,
  output logic [DW-1:0]     tablat,
  output logic [AW-1:0]     tbl_ptr,
  output logic              deny_err
);
  localparam int NREG       = NUM_BLKS + 1;
  localparam int IW         = $clog2(NREG);
  localparam int IMPL_LIMIT = NUM_BLKS * BLK_BYTES;

  logic [NREG-1:0] xg, wg, rg;
  logic [AW-1:0]   acc_addr;
  logic [IW-1:0]   tgt_reg, src_reg;
  logic            tgt_impl, src_impl;
  logic            busy, is_tbl, is_wr, accept, allow;
  logic [NREG-1:0] tgt_oh;
  pend_e           pend;
  ptr_mode_e       mode;

  assign mode   = ptr_mode_e'(opcode[1:0]);
  assign is_tbl = (opcode[15:3] == TBL_OPC_HI);
  assign is_wr  = opcode[2];
  assign accept = op_valid && is_tbl && !busy && !ptr_load;

  tbl_prot_bits #(.NREG(NREG)) i_bits (
    .clk(clk), .rst(rst), .cfg_we(cfg_we),
    .wd_xg(cfg_xg), .wd_wg(cfg_wg), .wd_rg(cfg_rg),
    .erase_req(erase_req), .ext_prog(ext_prog),
    .xg(xg), .wg(wg), .rg(rg)
  );

  tbl_ptr_unit #(.AW(AW)) i_ptr (
    .clk(clk), .rst(rst), .load(ptr_load), .load_val(ptr_load_val),
    .step_en(accept), .mode(mode), .ptr(tbl_ptr), .acc_addr(acc_addr)
  );

  tbl_region_dec #(.AW(AW), .BOOT_BYTES(BOOT_BYTES), .BLK_BYTES(BLK_BYTES),
                   .NUM_BLKS(NUM_BLKS)) i_tgt_dec (
    .addr(acc_addr), .region(tgt_reg), .implemented(tgt_impl)
  );

  tbl_region_dec #(.AW(AW), .BOOT_BYTES(BOOT_BYTES), .BLK_BYTES(BLK_BYTES),
                   .NUM_BLKS(NUM_BLKS)) i_src_dec (
    .addr(instr_addr), .region(src_reg), .implemented(src_impl)
  );

  always_comb begin
    tgt_oh = NREG'(1) << tgt_reg;
    if (ext_prog)   allow = |(xg & tgt_oh);
    else if (is_wr) allow = |(wg & tgt_oh);
    else            allow = |(rg & tgt_oh) || (src_impl && src_reg == tgt_reg);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      pend      <= PD_NONE;
      mem_addr  <= '0;
      mem_rd    <= 1'b0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      tablat    <= '0;
      deny_err  <= 1'b0;
    end else begin
      mem_rd   <= 1'b0;
      mem_we   <= 1'b0;
      deny_err <= 1'b0;
      if (busy) begin
        busy <= 1'b0;
        pend <= PD_NONE;
        if (pend == PD_DATA)      tablat <= mem_rdata;
        else if (pend == PD_ZERO) tablat <= '0;
      end
      if (accept) begin
        busy     <= 1'b1;
        mem_addr <= acc_addr;
        if (is_wr) mem_wdata <= wr_data;
        if (!tgt_impl) begin
          pend <= is_wr ? PD_NONE : PD_ZERO;
        end else if (allow) begin
          if (is_wr) mem_we <= 1'b1;
          else begin
            mem_rd <= 1'b1;
            pend   <= PD_DATA;
          end
        end else begin
          deny_err <= 1'b1;
          pend     <= is_wr ? PD_NONE : PD_ZERO;
        end
      end
    end
  end

  a_r11_err_single: assert property (@(posedge clk) disable iff (rst)
    deny_err |=> !deny_err);
  a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_we || deny_err) |=> !(mem_rd || mem_we || deny_err));
  a_r2_no_rd_unimpl: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_we) |-> (mem_addr < AW'(IMPL_LIMIT)));
  a_r8_other_opc: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !is_tbl && !busy) |=> !(mem_rd || mem_we || deny_err));
  a_r11_excl: assert property (@(posedge clk) disable iff (rst)
    $countones({mem_rd, mem_we, deny_err}) <= 1);
endmodule

// File: tb/test_tbl_guard_top.sv
module test_tbl_guard_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [15:0] opcode = '0;
  logic [20:0] instr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        ext_prog = 1'b0;
  logic        ptr_load = 1'b0;
  logic [20:0] ptr_load_val = '0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_xg = '1, cfg_wg = '1, cfg_rg = '1;
  logic        erase_req = 1'b0;
  logic [7:0]  mem_rdata;
  logic [20:0] mem_addr, tbl_ptr;
  logic        mem_rd, mem_we, deny_err;
  logic [7:0]  mem_wdata, tablat;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_fn(logic [20:0] a);
    return a[7:0] ^ {a[12:8], 3'b101} ^ a[20:13];
  endfunction

  assign mem_rdata = mem_fn(mem_addr);

  tbl_guard_top i_tbl_guard_top (
    .clk(clk), .rst(rst), .op_valid(op_valid), .opcode(opcode),
    .instr_addr(instr_addr), .wr_data(wr_data), .ext_prog(ext_prog),
    .ptr_load(ptr_load), .ptr_load_val(ptr_load_val), .cfg_we(cfg_we),
    .cfg_xg(cfg_xg), .cfg_wg(cfg_wg), .cfg_rg(cfg_rg), .erase_req(erase_req),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .tablat(tablat),
    .tbl_ptr(tbl_ptr), .deny_err(deny_err)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  function automatic int region_of(logic [20:0] a);
    if (a >= 21'h008000) return -1;
    if (a < 21'h000200) return 0;
    return int'(a / 21'h002000) + 1;
  endfunction

  logic [20:0] m_ptr, m_addr;
  logic [7:0]  m_tablat, m_wdata;
  logic        m_rd, m_we, m_err;
  int          m_busy, m_pend;
  logic [4:0]  m_xg, m_wg, m_rg;

  always @(posedge clk) begin
    if (rst) begin
      m_ptr = 0; m_addr = 0; m_tablat = 0; m_wdata = 0;
      m_rd = 0; m_we = 0; m_err = 0; m_busy = 0; m_pend = 0;
      m_xg = '1; m_wg = '1; m_rg = '1;
    end else begin
      int old_busy;
      logic [4:0] xg0, wg0, rg0;
      old_busy = m_busy;
      xg0 = m_xg; wg0 = m_wg; rg0 = m_rg;
      m_rd = 0; m_we = 0; m_err = 0;
      if (erase_req && ext_prog) begin m_xg = '1; m_wg = '1; m_rg = '1; end
      else if (cfg_we) begin m_xg &= cfg_xg; m_wg &= cfg_wg; m_rg &= cfg_rg; end
      if (old_busy != 0) begin
        if (m_pend == 1) m_tablat = mem_fn(m_addr);
        else if (m_pend == 2) m_tablat = 0;
        m_pend = 0; m_busy = 0;
      end
      if (ptr_load) m_ptr = ptr_load_val;
      else if (old_busy == 0 && op_valid && opcode >= 16'h0008 && opcode <= 16'h000F) begin
        int md, t, s;
        bit wr, ok;
        logic [20:0] a;
        md = int'(opcode[1:0]);
        wr = opcode[2];
        a  = (md == 3) ? m_ptr + 21'd1 : m_ptr;
        t  = region_of(a);
        s  = region_of(instr_addr);
        m_busy = 1;
        m_addr = a;
        if (wr) m_wdata = wr_data;
        if (t < 0) m_pend = wr ? 0 : 2;
        else begin
          if (ext_prog) ok = xg0[t];
          else if (wr)  ok = wg0[t];
          else          ok = rg0[t] || (s == t);
          if (ok) begin
            if (wr) m_we = 1; else begin m_rd = 1; m_pend = 1; end
          end else begin
            m_err = 1; m_pend = wr ? 0 : 2;
          end
        end
        if (md == 1 || md == 3) m_ptr = m_ptr + 21'd1;
        else if (md == 2) m_ptr = m_ptr - 21'd1;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk(tbl_ptr == m_ptr, "R7 pointer", 32'(tbl_ptr), 32'(m_ptr));
      chk(tablat == m_tablat, "R4 latch", 32'(tablat), 32'(m_tablat));
      chk(mem_rd == m_rd, "R1 read strobe", 32'(mem_rd), 32'(m_rd));
      chk(mem_we == m_we, "R3 write strobe", 32'(mem_we), 32'(m_we));
      chk(deny_err == m_err, "R11 deny pulse", 32'(deny_err), 32'(m_err));
      if (m_rd || m_we)
        chk(mem_addr == m_addr, "R10 access address", 32'(mem_addr), 32'(m_addr));
      if (m_we)
        chk(mem_wdata == m_wdata, "R3 write data", 32'(mem_wdata), 32'(m_wdata));
    end
  end

  // ---------------- stimulus helpers ----------------
  logic s_rd, s_we, s_err;
  logic [20:0] s_addr;

  task automatic load_ptr(logic [20:0] v);
    ptr_load = 1; ptr_load_val = v;
    @(negedge clk);
    ptr_load = 0;
  endtask

  task automatic clear_bits(logic [4:0] xm, logic [4:0] wm, logic [4:0] rm);
    cfg_we = 1; cfg_xg = xm; cfg_wg = wm; cfg_rg = rm;
    @(negedge clk);
    cfg_we = 0; cfg_xg = '1; cfg_wg = '1; cfg_rg = '1;
  endtask

  task automatic erase(logic ext);
    erase_req = 1; ext_prog = ext;
    @(negedge clk);
    erase_req = 0; ext_prog = 0;
  endtask

  task automatic do_op(logic [15:0] opc, logic [20:0] ia, logic [7:0] d, logic ext);
    op_valid = 1; opcode = opc; instr_addr = ia; wr_data = d; ext_prog = ext;
    @(negedge clk);
    s_rd = mem_rd; s_we = mem_we; s_err = deny_err; s_addr = mem_addr;
    op_valid = 0; ext_prog = 0;
    @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R9 watchdog expired actual=hung expected=done");
      finish_run;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk(tbl_ptr == 0 && tablat == 0 && !deny_err, "R12 reset state", 32'(tbl_ptr), 0);

    // R12/R7/R1: load then post-increment read inside region 1
    load_ptr(21'h000300);
    chk(tbl_ptr == 21'h000300, "R12 load", 32'(tbl_ptr), 32'h300);
    do_op(16'h0009, 21'h000400, 8'h00, 0);
    chk(s_rd && tablat == mem_fn(21'h000300), "R1 same-region read", 32'(tablat), 32'(mem_fn(21'h300)));
    chk(tbl_ptr == 21'h000301, "R7 post-increment", 32'(tbl_ptr), 32'h301);

    // R4: foreign read guard on region 2
    clear_bits('1, '1, 5'b11011);
    load_ptr(21'h002010);
    do_op(16'h0008, 21'h000100, 8'h00, 0);
    chk(s_err && !s_rd && tablat == 8'h00, "R4 foreign read denied", 32'(tablat), 0);
    chk(!deny_err, "R11 pulse one cycle", 32'(deny_err), 0);
    do_op(16'h0008, 21'h002500, 8'h00, 0);
    chk(!s_err && tablat == mem_fn(21'h002010), "R4 in-region read", 32'(tablat), 32'(mem_fn(21'h2010)));

    // R6: bits cannot be set by writes or by a non-external erase
    clear_bits('1, '1, '1);
    do_op(16'h0008, 21'h000100, 8'h00, 0);
    chk(s_err, "R6 write cannot raise bit", 32'(s_err), 1);
    erase(0);
    do_op(16'h0008, 21'h000100, 8'h00, 0);
    chk(s_err, "R6 erase needs programmer", 32'(s_err), 1);
    erase(1);
    do_op(16'h0008, 21'h000100, 8'h00, 0);
    chk(!s_err && tablat == mem_fn(21'h002010), "R6 external erase restores", 32'(tablat), 32'(mem_fn(21'h2010)));

    // R3: write guard on boot region
    clear_bits('1, 5'b11110, '1);
    load_ptr(21'h000010);
    do_op(16'h000C, 21'h003000, 8'hA5, 0);
    chk(!s_we && s_err, "R3 write suppressed", 32'(s_we), 0);
    load_ptr(21'h000210);
    do_op(16'h000C, 21'h003000, 8'h3C, 0);
    chk(s_we && !s_err && mem_wdata == 8'h3C, "R3 write permitted", 32'(mem_wdata), 32'h3C);

    // R5: external guard on region 4
    clear_bits(5'b01111, '1, 5'b11101);
    load_ptr(21'h006000);
    do_op(16'h0008, 21'h000100, 8'h00, 0);
    chk(s_rd && !s_err, "R5 guard ignored for program", 32'(s_rd), 1);
    do_op(16'h0008, 21'h000100, 8'h00, 1);
    chk(s_err && tablat == 8'h00, "R5 external read blocked", 32'(tablat), 0);
    do_op(16'h000C, 21'h000100, 8'h11, 1);
    chk(s_err && !s_we, "R5 external write blocked", 32'(s_we), 0);
    load_ptr(21'h000400);
    do_op(16'h0008, 21'h000100, 8'h00, 1);
    chk(s_rd && !s_err, "R5 external ignores read guard", 32'(s_rd), 1);

    // R2: unimplemented space
    load_ptr(21'h008000);
    do_op(16'h0008, 21'h000100, 8'h00, 0);
    chk(!s_rd && !s_err && tablat == 8'h00, "R2 unimplemented low edge", 32'(tablat), 0);
    load_ptr(21'h1FFFFF);
    do_op(16'h000C, 21'h000100, 8'h77, 0);
    chk(!s_we && !s_err, "R2 unimplemented write", 32'(s_we), 0);

    // R7: wrap both ways
    do_op(16'h0009, 21'h000100, 8'h00, 0);
    chk(tbl_ptr == 21'h000000, "R7 wrap up", 32'(tbl_ptr), 0);
    do_op(16'h000A, 21'h000100, 8'h00, 0);
    chk(tbl_ptr == 21'h1FFFFF, "R7 wrap down", 32'(tbl_ptr), 32'h1FFFFF);
    do_op(16'h000B, 21'h000100, 8'h00, 0);
    chk(tbl_ptr == 21'h000000, "R7 pre-increment wrap", 32'(tbl_ptr), 0);

    // R10: region 1 read guard is clear; boot instruction at boundary
    load_ptr(21'h0001FF);
    do_op(16'h000B, 21'h000100, 8'h00, 0);
    chk(s_err && s_addr == 21'h000200, "R10 pre-increment checks new address", 32'(s_err), 1);
    load_ptr(21'h0001FF);
    do_op(16'h0009, 21'h000100, 8'h00, 0);
    chk(!s_err && s_rd && tablat == mem_fn(21'h0001FF), "R10 post-increment checks old address", 32'(tablat), 32'(mem_fn(21'h1FF)));

    // R8: other opcodes
    load_ptr(21'h000050);
    do_op(16'h0007, 21'h000100, 8'h00, 0);
    chk(!s_rd && !s_we && !s_err && tbl_ptr == 21'h000050, "R8 opcode below range", 32'(tbl_ptr), 32'h50);
    do_op(16'h0010, 21'h000100, 8'h00, 0);
    chk(!s_rd && !s_we && tbl_ptr == 21'h000050, "R8 opcode above range", 32'(tbl_ptr), 32'h50);

    // R9: request held into the busy cycle is ignored
    op_valid = 1; opcode = 16'h0009; instr_addr = 21'h000100;
    @(negedge clk);
    chk(tbl_ptr == 21'h000051, "R9 first accepted", 32'(tbl_ptr), 32'h51);
    @(negedge clk);
    op_valid = 0;
    chk(tbl_ptr == 21'h000051 && !mem_rd, "R9 busy request ignored", 32'(tbl_ptr), 32'h51);

    // R12: load wins over a request in the same cycle
    op_valid = 1; opcode = 16'h0009; ptr_load = 1; ptr_load_val = 21'h000123;
    @(negedge clk);
    op_valid = 0; ptr_load = 0;
    chk(tbl_ptr == 21'h000123 && !mem_rd, "R12 load beats request", 32'(tbl_ptr), 32'h123);
    repeat (3) @(negedge clk);
    finish_run;
  end
endmodule